// File: doc/BRIEF.md
# Stepped Fan Duty Controller

This block turns a CPU temperature, given in whole degrees Celsius, into an 8-bit PWM duty for the cooling fan. The temperature selects one of ten levels: stopped, eight stepped levels, or full speed. Once a stepped level has been reached, it is held until the temperature falls a fixed margin below that level's entry point. The fan therefore does not hunt around a trip point.

The duty applied to the fan does not jump straight to the level's target. On each update tick it moves toward the target by a step that depends on the distance that remains: large gaps close quickly and small gaps close gently. The duty never passes the target. Rising and falling moves each have their own step table.

A fan-failure monitor raises a flag when three conditions hold together for a programmable number of consecutive ticks: the CPU is hot, the fan is being driven, and the tachometer reports no rotation. An external timer supplies the tick, so the level, the duty and the monitor all advance at the update rate and not at the clock rate.

Top module: `fan_step_ctrl`

## Requirements
- R1: After reset, `duty_o` and `target_o` are 0 and `fan_fail_o` is 0.
- R2: When `tick_i` is low, `duty_o`, `target_o` and `fan_fail_o` keep their values whatever the other inputs do.
- R3: Eight entry temperatures lie 5 degrees apart, starting at 55 (55, 60, ..., 90). When the temperature rises to the entry temperature of stepped level k (k = 1..8) or above it, `target_o` becomes 73 + 22*(k-1) one clock after the tick, provided it was lower.
- R4: A tick with a temperature of 95 or more sets `target_o` to 255. When the temperature then falls below 95, the level becomes the highest stepped level whose hysteresis floor the temperature still meets.
- R5: Stepped level k (k = 2..8) is left only on a tick where the temperature is below its entry temperature minus 3. The level then drops to the highest level whose floor is still met.
- R6: A tick with a temperature below 50 sets `target_o` to 0. Between 50 and 54, a running fan holds stepped level 1 (target 73), and a stopped fan stays at 0 until the temperature reaches 55.
- R7: On a tick where the target exceeds the duty, the duty rises by 1, 2, 4 or 6 for a gap of at most 6, at most 12, at most 22, or larger. It lands exactly on the target when the step would reach or pass it.
- R8: On a tick where the target is below the duty, the duty falls using the same gap bands and step sizes, and it never goes below the target.
- R9: A fault condition is a tick with a temperature of at least 65, a nonzero duty before the tick, and `tach_ok_i` low. `fan_fail_o` goes high after `fail_ticks_i` consecutive such ticks. It clears on the first tick that is not a fault condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Update enable: one evaluation per cycle in which it is high |
| temp_i | input | 8 | CPU temperature in degrees Celsius, unsigned |
| tach_ok_i | input | 1 | High when the tachometer sees rotation |
| fail_ticks_i | input | 16 | Consecutive fault ticks needed to flag a failure |
| duty_o | output | 8 | Applied PWM duty, slew limited |
| target_o | output | 8 | Duty of the currently selected level |
| fan_fail_o | output | 1 | Fan failure flag |

## Verification
The assertions assume that `temp_i`, `tach_ok_i` and `fail_ticks_i` are sampled only on a tick, and that they hold steady through the clock edge at which `tick_i` is high. The bench meets this by changing every input half a cycle away from the rising edge. The bench also keeps `fail_ticks_i` small, so that the failure delay is reached within a short run. Stimulus sweeps the temperature up through every entry point and down through every hysteresis floor. It also visits the band between 50 and 55 from both a running fan and a stopped fan, and runs some phases with a sparse tick pattern. The bench's reference model follows the level, duty and fault count on every clock.

// File: rtl/fan_step_pkg.sv
package fan_step_pkg;
  // gap band limits and step sizes for one slew direction
  typedef struct packed {
    logic [7:0] lim1;
    logic [7:0] lim2;
    logic [7:0] lim3;
    logic [7:0] st1;
    logic [7:0] st2;
    logic [7:0] st3;
    logic [7:0] st4;
  } slew_cfg_t;

  localparam slew_cfg_t SLEW_DEF = '{lim1: 8'd6, lim2: 8'd12, lim3: 8'd22,
                                     st1: 8'd1, st2: 8'd2, st3: 8'd4, st4: 8'd6};

  function automatic int unsigned slew_step(slew_cfg_t c, int unsigned gap);
    if (gap <= 32'(c.lim1))      return 32'(c.st1);
    else if (gap <= 32'(c.lim2)) return 32'(c.st2);
    else if (gap <= 32'(c.lim3)) return 32'(c.st3);
    else                         return 32'(c.st4);
  endfunction
endpackage

// File: rtl/fan_level_sel.sv
module fan_level_sel #(
  parameter int TEMP_W    = 8,
  parameter int N_TRIP    = 8,
  parameter int TRIP_BASE = 55,
  parameter int TRIP_GAP  = 5,
  parameter int HYST      = 3,
  parameter int STOP_T    = 50,
  parameter int FULL_T    = 95,
  parameter int LVL_W     = $clog2(N_TRIP + 2)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [TEMP_W-1:0] temp_i,
  output logic [LVL_W-1:0]  level_o,
  output logic [LVL_W-1:0]  level_nxt_o
);
  localparam logic [LVL_W-1:0] LVL_FULL = LVL_W'(N_TRIP + 1);

  logic [N_TRIP-1:0] hit_up, hit_dn;
  logic [LVL_W-1:0]  n_up, n_dn, level_q;

  for (genvar k = 0; k < N_TRIP; k++) begin : g_trip
    localparam int TRIP = TRIP_BASE + TRIP_GAP * k;
    assign hit_up[k] = 32'(temp_i) >= TRIP;
    if (k == 0) begin : g_first
      // lowest level exits at the stop threshold, not by hysteresis
      assign hit_dn[k] = 32'(temp_i) >= STOP_T;
    end else begin : g_rest
      assign hit_dn[k] = 32'(temp_i) + HYST >= TRIP;
    end
  end

  always_comb begin
    n_up = '0;
    n_dn = '0;
    for (int k = 0; k < N_TRIP; k++) begin
      n_up = n_up + LVL_W'(hit_up[k]);
      n_dn = n_dn + LVL_W'(hit_dn[k]);
    end
    if (32'(temp_i) >= FULL_T)     level_nxt_o = LVL_FULL;
    else if (32'(temp_i) < STOP_T) level_nxt_o = '0;
    else if (n_up > level_q)       level_nxt_o = n_up;
    else if (n_dn < level_q)       level_nxt_o = n_dn;
    else                           level_nxt_o = level_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)     level_q <= '0;
    else if (tick_i) level_q <= level_nxt_o;

  assign level_o = level_q;

  a_r4_full_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && 32'(temp_i) >= FULL_T |=> level_o == LVL_FULL);
  a_r6_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && 32'(temp_i) < STOP_T |=> level_o == '0);
  a_r2_level_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(level_o));
endmodule

// File: rtl/fan_slew.sv
module fan_slew
  import fan_step_pkg::*;
#(
  parameter int        DUTY_W = 8,
  parameter slew_cfg_t RISE   = SLEW_DEF,
  parameter slew_cfg_t FALL   = SLEW_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [DUTY_W-1:0] target_i,
  output logic [DUTY_W-1:0] duty_o
);
  logic [DUTY_W-1:0] duty_q, gap, step, duty_nxt;
  logic              rise;

  always_comb begin
    rise = target_i > duty_q;
    gap  = rise ? target_i - duty_q : duty_q - target_i;
    step = DUTY_W'(slew_step(rise ? RISE : FALL, 32'(gap)));
    if (step >= gap)  duty_nxt = target_i;
    else if (rise)    duty_nxt = duty_q + step;
    else              duty_nxt = duty_q - step;
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)     duty_q <= '0;
    else if (tick_i) duty_q <= duty_nxt;

  assign duty_o = duty_q;

  a_r7_rise_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && target_i >= duty_o |=> duty_o <= $past(target_i) && duty_o >= $past(duty_o));
  a_r8_fall_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && target_i <= duty_o |=> duty_o >= $past(target_i) && duty_o <= $past(duty_o));
  a_r7_max_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> (32'(duty_o) + 6 >= 32'($past(duty_o))) && (32'(duty_o) <= 32'($past(duty_o)) + 6));
endmodule

// File: rtl/fan_fail_mon.sv
module fan_fail_mon #(
  parameter int TEMP_W = 8,
  parameter int DUTY_W = 8,
  parameter int CNT_W  = 16,
  parameter int FAIL_T = 65
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [TEMP_W-1:0] temp_i,
  input  logic [DUTY_W-1:0] duty_i,
  input  logic              tach_ok_i,
  input  logic [CNT_W-1:0]  limit_i,
  output logic              fail_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   cnt_inc;
  logic             fault;

  assign fault   = 32'(temp_i) >= FAIL_T && duty_i != '0 && !tach_ok_i;
  assign cnt_inc = {1'b0, cnt_q} + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      cnt_q  <= '0;
      fail_o <= 1'b0;
    end else if (tick_i) begin
      if (fault) begin
        if (!(&cnt_q)) cnt_q <= cnt_q + 1'b1;
        fail_o <= cnt_inc >= {1'b0, limit_i};
      end else begin
        cnt_q  <= '0;
        fail_o <= 1'b0;
      end
    end

  a_r9_rise_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fail_o) |-> $past(tick_i && !tach_ok_i && duty_i != '0));
  a_r9_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && tach_ok_i |=> !fail_o);
endmodule

// File: rtl/fan_step_ctrl.sv
module fan_step_ctrl
  import fan_step_pkg::*;
#(
  parameter int        TEMP_W    = 8,
  parameter int        DUTY_W    = 8,
  parameter int        N_TRIP    = 8,
  parameter int        TRIP_BASE = 55,
  parameter int        TRIP_GAP  = 5,
  parameter int        DUTY_BASE = 73,
  parameter int        DUTY_INC  = 22,
  parameter int        HYST      = 3,
  parameter int        STOP_T    = 50,
  parameter int        FULL_T    = 95,
  parameter int        FAIL_T    = 65,
  parameter int        CNT_W     = 16,
  parameter slew_cfg_t RISE      = SLEW_DEF,
  parameter slew_cfg_t FALL      = SLEW_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [TEMP_W-1:0] temp_i,
  input  logic              tach_ok_i,
  input  logic [CNT_W-1:0]  fail_ticks_i,
  output logic [DUTY_W-1:0] duty_o,
  output logic [DUTY_W-1:0] target_o,
  output logic              fan_fail_o
);
  localparam int LVL_W = $clog2(N_TRIP + 2);

  logic [LVL_W-1:0]  level, level_nxt;
  logic [DUTY_W-1:0] target_nxt;

  function automatic logic [DUTY_W-1:0] lvl_duty(logic [LVL_W-1:0] l);
    if (l == '0)                 return '0;
    else if (32'(l) > N_TRIP)    return '1;
    else                         return DUTY_W'(DUTY_BASE + DUTY_INC * (32'(l) - 1));
  endfunction

  fan_level_sel #(
    .TEMP_W(TEMP_W), .N_TRIP(N_TRIP), .TRIP_BASE(TRIP_BASE), .TRIP_GAP(TRIP_GAP),
    .HYST(HYST), .STOP_T(STOP_T), .FULL_T(FULL_T), .LVL_W(LVL_W)
  ) u_level (
    .clk_i, .rst_ni, .tick_i, .temp_i,
    .level_o(level), .level_nxt_o(level_nxt)
  );

  assign target_nxt = lvl_duty(level_nxt);
  assign target_o   = lvl_duty(level);

  fan_slew #(.DUTY_W(DUTY_W), .RISE(RISE), .FALL(FALL)) u_slew (
    .clk_i, .rst_ni, .tick_i, .target_i(target_nxt), .duty_o
  );

  fan_fail_mon #(.TEMP_W(TEMP_W), .DUTY_W(DUTY_W), .CNT_W(CNT_W), .FAIL_T(FAIL_T)) u_fail (
    .clk_i, .rst_ni, .tick_i, .temp_i, .duty_i(duty_o), .tach_ok_i,
    .limit_i(fail_ticks_i), .fail_o(fan_fail_o)
  );

  a_r8_no_overshoot_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
    duty_o > $past(duty_o) |-> duty_o <= target_o);
  a_r8_no_overshoot_dn: assert property (@(posedge clk_i) disable iff (!rst_ni)
    duty_o < $past(duty_o) |-> duty_o >= target_o);
  a_r2_duty_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(duty_o) && $stable(fan_fail_o));
endmodule

// File: tb/fan_step_ctrl_tb.sv
`timescale 1ns/1ps
module fan_step_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic [7:0]  temp = 8'd25;
  logic        tach_ok = 1'b1;
  logic [15:0] fail_ticks = 16'd5;
  logic [7:0]  duty, target;
  logic        fail;

  int n_chk = 0, n_bad = 0;
  string cur_req = "R1";
  bit checking = 1'b0;

  int m_lvl = 0, m_duty = 0, m_run = 0;
  bit m_fail = 1'b0;

  always #2.5 clk = ~clk;

  fan_step_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .temp_i(temp),
    .tach_ok_i(tach_ok), .fail_ticks_i(fail_ticks),
    .duty_o(duty), .target_o(target), .fan_fail_o(fail)
  );

  function automatic int entry_t(int k);
    return 50 + 5 * k;
  endfunction

  function automatic int lvl_target(int l);
    if (l == 0) return 0;
    if (l == 9) return 255;
    return 73 + 22 * (l - 1);
  endfunction

  // behavioural reference, updated at the same edge the design updates
  always @(posedge clk) begin
    if (!rst_n) begin
      m_lvl = 0; m_duty = 0; m_run = 0; m_fail = 1'b0;
    end else if (tick) begin
      int t, hi, tg, gap, st;
      t = temp;
      if (t >= 65 && m_duty != 0 && !tach_ok) begin
        m_run++;
        m_fail = (m_run >= fail_ticks);
      end else begin
        m_run = 0;
        m_fail = 1'b0;
      end
      if (t >= 95) m_lvl = 9;
      else if (t < 50) m_lvl = 0;
      else begin
        hi = 0;
        for (int k = 1; k <= 8; k++) if (t >= entry_t(k)) hi = k;
        if (hi > m_lvl) m_lvl = hi;
        else begin
          if (m_lvl == 9) m_lvl = 8;
          while (m_lvl >= 2 && t < entry_t(m_lvl) - 3) m_lvl--;
        end
      end
      tg = lvl_target(m_lvl);
      gap = (tg > m_duty) ? tg - m_duty : m_duty - tg;
      st = (gap <= 6) ? 1 : (gap <= 12) ? 2 : (gap <= 22) ? 4 : 6;
      if (st >= gap) m_duty = tg;
      else if (tg > m_duty) m_duty += st;
      else m_duty -= st;
    end
  end

  task automatic check(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (checking) begin
      check(cur_req, "duty_o", duty, m_duty);
      check(cur_req, "target_o", target, lvl_target(m_lvl));
      check(cur_req, "fan_fail_o", fail, m_fail);
    end
  end

  task automatic run(string req, int t, int n, int div = 1);
    cur_req = req;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      temp = 8'(t);
      tick = (i % div) == 0;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "reset duty", duty, 0);
    check("R1", "reset target", target, 0);
    check("R1", "reset fail", fail, 0);
    checking = 1'b1;
    // R2: hot input but no tick
    temp = 8'd100;
    cur_req = "R2";
    repeat (10) @(negedge clk);
    check("R2", "no tick duty", duty, 0);
    // R6: stopped fan stays off in the band below the first entry point
    run("R6", 52, 10);
    check("R6", "stopped band target", target, 0);
    // R3 / R7: rising through every entry point
    for (int k = 1; k <= 8; k++) run("R3", entry_t(k), 30);
    run("R7", 56, 1);
    run("R7", 90, 40, 3);
    // R4: full speed and exit from it
    run("R4", 97, 30);
    check("R4", "full target", target, 255);
    run("R4", 93, 20);
    check("R4", "exit full target", target, 227);
    // R5 / R8: falling one degree at a time
    for (int t = 92; t >= 51; t--) run("R5", t, 6);
    check("R6", "running band target", target, 73);
    run("R8", 49, 40);
    run("R6", 54, 10);
    check("R6", "no restart below 55", target, 0);
    run("R6", 55, 30);
    run("R8", 97, 50);
    run("R8", 60, 60, 2);
    // R9: failure with missing tach, hot and driven
    fail_ticks = 16'd5;
    tach_ok = 1'b0;
    run("R9", 70, 12);
    check("R9", "fail set", fail, 1);
    tach_ok = 1'b1;
    run("R9", 70, 3);
    check("R9", "fail cleared", fail, 0);
    tach_ok = 1'b0;
    run("R9", 62, 15);
    check("R9", "cool no fail", fail, 0);
    fail_ticks = 16'd3;
    run("R9", 66, 10, 2);
    tach_ok = 1'b1;
    run("R9", 40, 60);
    checking = 1'b0;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #900us;
    n_bad++;
    n_chk++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule